// File: doc/BRIEF.md
# Burst Transition Clock Generator

This block drives one output line that toggles a set number of times, spaced a fixed number of system clocks apart. It generates the serial clock for an SPI-style transfer: the controller sets the spacing once, then writes a toggle count to start each burst. A count of twice the bit count gives one full clock period per data bit, and the line returns to low when the burst ends.

The spacing comes from a pacing counter that runs freely from the moment the block is enabled. It is not restarted by a count write. A burst therefore starts on the next pacing tick after the write, and its phase depends on how long after enable the write arrives. With a spacing of one clock, a tick occurs on every clock and the phase is always the same. A one-cycle completion pulse and a busy level let the controller avoid restarting a burst partway through. A restart partway through could leave the line idling high. Several instances can run side by side, each with its own enable.

Top module: `xclk_burst_gen`

## Requirements
- R1: While `en` is low (sampled at a clock edge), after that edge `sck` is 0, `busy` is 0, `done` is 0, and the pacing counter restarts from zero when `en` next goes high.
- R2: With spacing value T (T >= 1), toggles of `sck` in a burst are exactly T clocks apart. T = 1 toggles on every clock.
- R3: A spacing value of 0 behaves exactly like a spacing value of 1.
- R4: A count write of N >= 1 produces exactly N toggles of `sck`. `busy` is 1 from the edge that takes the write until the edge of the last toggle. `done` is 1 for exactly the one cycle that follows the edge of the last toggle.
- R5: Count the enabled edges from 0, starting at the first edge where `en` is sampled high. Pacing ticks fall on edges m with (m+1) mod T = 0. If the count is written at edge w, the first toggle happens at the first tick edge strictly after w.
- R6: A count write during a burst replaces the remaining count. No toggle happens at the edge that takes the write. A write of 0 ends the burst with `sck` held where it is and no `done` pulse.
- R7: Count writes made while `en` is low are ignored. No toggle and no `busy` follows once `en` rises.
- R8: With T = 1, a count of 64 gives 32 rising edges of `sck` and leaves `sck` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable. When low, holds the block idle with `sck` low |
| tb_wr | input | 1 | Write strobe for the spacing register |
| tb_data | input | TB_W | Spacing value: system clocks per toggle (0 is treated as 1) |
| cnt_wr | input | 1 | Count write strobe. Starts or replaces a burst |
| cnt_data | input | CNT_W | Number of toggles in the burst |
| sck | output | 1 | Generated clock line (registered) |
| busy | output | 1 | A burst has toggles left |
| done | output | 1 | One-cycle pulse after the final toggle |

## Verification
The assertions take for granted that the spacing register is not rewritten between a tick and the next cycle when the pulse-gap property is being checked. They also assume `en` is a clean synchronous level. The stimulus meets these assumptions by writing the spacing only while `en` is low. All strobes are driven away from the active edge. The sweep covers every spacing value from 0 to 4, write offsets 0 to 4 from enable, and counts 1 to 5. It then runs a replacement, a cancellation, a write while disabled, and a full 64-toggle burst.

// File: rtl/xclk_pkg.sv
// Package: shared widths and helpers for the burst clock generator.
// Assumes: nothing beyond the default spacing register width.
package xclk_pkg;
    parameter int unsigned XCLK_TB_W = 16;

    // Effective spacing: a programmed 0 behaves as 1.
    function automatic logic [XCLK_TB_W-1:0] eff_spacing(input logic [XCLK_TB_W-1:0] v);
        return (v == '0) ? XCLK_TB_W'(1) : v;
    endfunction
endpackage

// File: rtl/xclk_pacer.sv
// Module: xclk_pacer
// Holds the spacing register and a free-running pacing counter that runs
// from the moment `en` is high and emits a one-cycle tick every T clocks.
// Assumes: the spacing register survives `en` low; only rst_n resets it.
module xclk_pacer
    import xclk_pkg::*;
#(
    parameter int unsigned TB_W = XCLK_TB_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tb_wr,
    input  logic [TB_W-1:0] tb_data,
    output logic            tick
);
    logic [TB_W-1:0] tb_q;
    logic [TB_W-1:0] ctr;
    logic [TB_W-1:0] eff;

    // Spacing register: loaded by strobe, defaults to one clock per toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)     tb_q <= TB_W'(1);
        else if (tb_wr) tb_q <= tb_data;
    end

    // Zero maps to one.
    always_comb eff = (tb_q == '0) ? TB_W'(1) : tb_q;

    // Tick when the counter reaches the end of its period (>= covers a shrink).
    always_comb tick = en && (ctr >= eff - TB_W'(1));

    // Pacing counter: cleared while disabled, wraps at every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) ctr <= '0;
        else if (tick)     ctr <= '0;
        else               ctr <= ctr + TB_W'(1);
    end

    // R1: the counter restarts from zero after a disabled cycle.
    assert_ctr_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ctr == '0));

    // R2: with a spacing above one and no rewrite, ticks never come back to back.
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !tb_wr && eff != TB_W'(1)) |=> !tick);
endmodule

// File: rtl/xclk_burst.sv
// Module: xclk_burst
// Holds the remaining toggle count and the registered output line. It
// toggles on each pacing tick while toggles remain and pulses done after
// the final toggle.
// Assumes: tick comes from xclk_pacer in the same enable domain. A count
// write takes priority over a tick in the same cycle.
module xclk_burst #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_data,
    output logic             sck,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] remain;

    // Burst state: load or replace on write, else step once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            remain <= '0;
            sck    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cnt_wr) begin
                remain <= cnt_data;
            end else if (tick && remain != '0) begin
                sck    <= ~sck;
                remain <= remain - CNT_W'(1);
                done   <= (remain == CNT_W'(1));
            end
        end
    end

    // Toggles are still owed.
    always_comb busy = (remain != '0);

    // R1: a disabled edge leaves the line low and the burst idle.
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sck && !busy && !done));

    // R4: the completion pulse never overlaps outstanding toggles.
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: the line only moves while toggles were owed.
    assert_toggle_owed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && sck != $past(sck)) |-> ($past(remain) != '0));

    // R6: without a write, the count holds or steps down by exactly one.
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cnt_wr) |=> (remain == $past(remain) || remain == $past(remain) - CNT_W'(1)));
endmodule

// File: rtl/xclk_burst_gen.sv
// Module: xclk_burst_gen (top)
// Timed burst clock generator: the pacer supplies ticks every T clocks from
// enable, and the burst stage turns them into N toggles of sck.
// Assumes: synchronous active-low reset, en is synchronous to clk.
module xclk_burst_gen
    import xclk_pkg::*;
#(
    parameter int unsigned TB_W  = XCLK_TB_W,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tb_wr,
    input  logic [TB_W-1:0]  tb_data,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_data,
    output logic             sck,
    output logic             busy,
    output logic             done
);
    logic tick;

    xclk_pacer #(.TB_W(TB_W)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tb_wr   (tb_wr),
        .tb_data (tb_data),
        .tick    (tick)
    );

    xclk_burst #(.CNT_W(CNT_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .cnt_data (cnt_data),
        .sck      (sck),
        .busy     (busy),
        .done     (done)
    );
endmodule

// File: tb/sim_xclk_burst_gen.sv
module sim_xclk_burst_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        tb_wr = 1'b0;
    logic [15:0] tb_data = '0;
    logic        cnt_wr = 1'b0;
    logic [7:0]  cnt_data = '0;
    logic        sck, busy, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xclk_burst_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .tb_wr(tb_wr), .tb_data(tb_data),
        .cnt_wr(cnt_wr), .cnt_data(cnt_data), .sck(sck), .busy(busy), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Disable for two cycles with the spacing written, checking the idle state (R1).
    task automatic idle_and_set(input int t);
        en = 1'b0; tb_wr = 1'b1; tb_data = 16'(t);
        @(posedge clk); @(negedge clk);
        tb_wr = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 sck idle", int'(sck), 0);
        check("R1 busy idle", int'(busy), 0);
        check("R1 done idle", int'(done), 0);
    endtask

    // One burst: count n written at enabled edge w with spacing value t (R2 R3 R4 R5).
    task automatic burst_trial(input int t, input int w, input int n);
        int te, m1, last, nt;
        te = (t == 0) ? 1 : t;
        m1 = ((w + 1) / te + 1) * te - 1;
        last = m1 + (n - 1) * te;
        idle_and_set(t);
        en = 1'b1;
        for (int i = 0; i <= last + 2; i++) begin
            cnt_wr = (i == w); cnt_data = 8'(n);
            @(posedge clk); @(negedge clk);
            cnt_wr = 1'b0;
            if (i < m1) nt = 0;
            else nt = ((i - m1) / te + 1 < n) ? (i - m1) / te + 1 : n;
            check(t == 0 ? "R3 sck" : "R2 R5 sck", int'(sck), nt % 2);
            check("R4 busy", int'(busy), (i >= w && nt < n) ? 1 : 0);
            check("R4 done", int'(done), (i == last) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset sck", int'(sck), 0);
        check("R1 reset busy", int'(busy), 0);

        for (int t = 0; t <= 4; t++)
            for (int w = 0; w <= 4; w++)
                for (int n = 1; n <= 5; n++)
                    burst_trial(t, w, n);

        // R6: replacement mid-burst with an odd remainder leaves sck high.
        idle_and_set(1);
        en = 1'b1;
        cnt_wr = 1'b1; cnt_data = 8'd4;
        @(posedge clk); @(negedge clk);               // edge 0: load
        cnt_wr = 1'b0;
        @(posedge clk); @(negedge clk);               // edge 1: toggle
        check("R6 first toggle", int'(sck), 1);
        cnt_wr = 1'b1; cnt_data = 8'd2;
        @(posedge clk); @(negedge clk);               // edge 2: replace, no toggle
        cnt_wr = 1'b0;
        check("R6 no toggle on write", int'(sck), 1);
        check("R6 busy after replace", int'(busy), 1);
        @(posedge clk); @(negedge clk);               // edge 3
        check("R6 toggle 2", int'(sck), 0);
        @(posedge clk); @(negedge clk);               // edge 4: last
        check("R6 inverted idle", int'(sck), 1);
        check("R6 done", int'(done), 1);
        @(posedge clk); @(negedge clk);
        check("R6 busy end", int'(busy), 0);
        check("R6 sck stays high", int'(sck), 1);

        // R6: a write of 0 cancels without a done pulse.
        idle_and_set(2);
        en = 1'b1;
        cnt_wr = 1'b1; cnt_data = 8'd6;
        @(posedge clk); @(negedge clk);
        cnt_wr = 1'b0;
        @(posedge clk); @(negedge clk);               // edge 1: tick, toggle
        check("R6 cancel pre", int'(sck), 1);
        cnt_wr = 1'b1; cnt_data = 8'd0;
        @(posedge clk); @(negedge clk);
        cnt_wr = 1'b0;
        for (int k = 0; k < 6; k++) begin
            check("R6 cancel busy", int'(busy), 0);
            check("R6 cancel done", int'(done), 0);
            check("R6 cancel sck", int'(sck), 1);
            @(posedge clk); @(negedge clk);
        end

        // R7: count write while disabled is ignored.
        idle_and_set(1);
        cnt_wr = 1'b1; cnt_data = 8'd3;
        @(posedge clk); @(negedge clk);
        cnt_wr = 1'b0;
        en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); @(negedge clk);
            check("R7 busy", int'(busy), 0);
            check("R7 sck", int'(sck), 0);
        end

        // R8: 64 toggles at T=1 give 32 periods and end low.
        begin
            int rises, dones;
            logic prev;
            rises = 0; dones = 0;
            idle_and_set(1);
            en = 1'b1;
            cnt_wr = 1'b1; cnt_data = 8'd64;
            prev = sck;
            @(posedge clk); @(negedge clk);
            cnt_wr = 1'b0;
            for (int k = 0; k < 70; k++) begin
                @(posedge clk); @(negedge clk);
                if (sck && !prev) rises++;
                if (done) dones++;
                prev = sck;
            end
            check("R8 rising edges", rises, 32);
            check("R8 final level", int'(sck), 0);
            check("R8 done pulses", dones, 1);
        end

        en = 1'b0;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule